// File: doc/BRIEF.md
# Periodic Source Health Monitor

This block watches a single periodic data source through a one-cycle arrival strobe. It judges the source's health and reports it to a downstream aggregator as three single-cycle event pulses. While the source is healthy, each expected message that fails to arrive within the timeout window raises `miss_pulse`. A run of consecutive lost messages long enough to declare a fault raises `err_pulse` instead, and the monitor enters a fault mode. In that mode it waits for an unbroken run of arrivals, then raises `ok_pulse` and returns to normal operation. A single timeout during recovery throws away all recovery progress.

A cycle timer measures the time since the last event. The timeout window is `PERIOD + 2*JITTER` cycles. An occurrence counter holds either the current loss streak or the recovery streak. An arrival accepted in normal mode starts a processing interval. Its length comes from `proc_len`, is captured with the strobe, and is clamped to `[PROC_MIN, PROC_MAX]`. The message payload itself is not part of this block.

The strobe carries no payload and has no ready signal, so the block applies no back-pressure. Strobes that arrive during a processing interval are discarded without effect, and the source is never stalled.

Top module: `src_health_monitor`

## Requirements
- R1: After reset the monitor is in normal mode with both counts zero and all pulses low; with no strobe, the first `miss_pulse` appears exactly TIMEOUT = PERIOD+2*JITTER cycles after reset is released.
- R2: In normal mode, each TIMEOUT cycles without an accepted strobe produce one `miss_pulse` while the loss streak is below MISS_LIMIT-1, and the streak grows by one.
- R3: The timeout that completes MISS_LIMIT consecutive losses (default 3) raises `err_pulse` and not `miss_pulse`, and enters fault mode.
- R4: A strobe accepted in normal mode clears the loss streak and restarts the timer, so MISS_LIMIT further timeouts are needed before `err_pulse`.
- R5: An accepted normal-mode strobe starts a processing interval of D cycles, where D is `proc_len` clamped to [PROC_MIN, PROC_MAX] (defaults 2 and 6). Strobes sampled on the D edges that follow are ignored and do not restart the timer; a strobe on edge D+1 is accepted.
- R6: In fault mode, the RECOVER_COUNT-th consecutive strobe (default 2) raises `ok_pulse` on the cycle after its sampling edge. The monitor then returns to normal mode with a zero streak and a restarted timer.
- R7: In fault mode, a timeout clears the recovery streak and emits neither `miss_pulse` nor `err_pulse`.
- R8: When a strobe and a timeout fall on the same edge, the strobe wins and no `miss_pulse` is produced.
- R9: Each pulse lasts exactly one cycle, and at most one of the three pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_strobe | input | 1 | One-cycle message arrival indication |
| proc_len | input | LEN_W | Requested processing length, captured with an accepted strobe |
| miss_pulse | output | 1 | One expected message lost in normal mode |
| err_pulse | output | 1 | Fault declared |
| ok_pulse | output | 1 | Recovery completed |

## Verification
All pulses come from registers. A pulse caused at the edge that samples a strobe, or at a timeout edge, can be seen in the cycle right after that edge. The first miss after reset or after an accepted strobe is therefore due exactly TIMEOUT edges later, and each following miss or error comes TIMEOUT edges after the one before. The bench drives and samples on the falling edge and counts falling edges from each stimulus. It compares the exact offset of the first pulse of each kind, and the pulse counts, against those figures. The clamp and ignore rule is checked by probing a second strobe just inside and just outside each processing interval. The offset of the next miss shows which of the two restarted the timer.

// File: rtl/srcmon_pkg.sv
package srcmon_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_BUSY   = 2'd1,
    ST_FAULT  = 2'd2
  } mon_state_e;
endpackage

// File: rtl/srcmon_timer.sv
module srcmon_timer #(
  parameter int LIMIT = 16,
  parameter int T_W   = $clog2(LIMIT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  output logic [T_W-1:0] count,
  output logic           expired
);
  localparam logic [T_W-1:0] LAST = T_W'(LIMIT - 1);
  localparam logic [T_W-1:0] TOP  = {T_W{1'b1}};

  logic [T_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            count_q <= '0;
    else if (clr)          count_q <= '0;
    else if (count_q != TOP) count_q <= count_q + 1'b1;
  end

  assign count   = count_q;
  assign expired = (count_q == LAST);

  // R2: the controller always restarts the timer at or before the window end
  a_r2_timer_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= LAST);
endmodule

// File: rtl/srcmon_run_counter.sv
module srcmon_run_counter #(
  parameter int LIMIT = 3,
  parameter int N_W   = $clog2(LIMIT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           inc,
  output logic [N_W-1:0] count
);
  logic [N_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   count_q <= '0;
    else if (clr) count_q <= '0;
    else if (inc) count_q <= count_q + 1'b1;
  end

  assign count = count_q;

  // R3: a streak never reaches the limit of the larger of the two counts
  a_r3_streak_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_q) < LIMIT);
endmodule

// File: rtl/srcmon_busy_window.sv
module srcmon_busy_window #(
  parameter int LEN_W    = 4,
  parameter int PROC_MIN = 2,
  parameter int PROC_MAX = 6,
  parameter int T_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic [T_W-1:0]   elapsed,
  output logic             done
);
  localparam logic [T_W-1:0] LO = T_W'(PROC_MIN);
  localparam logic [T_W-1:0] HI = T_W'(PROC_MAX);

  logic [T_W-1:0] len_d, len_q;

  always_comb begin
    if (int'(len_in) < PROC_MIN)      len_d = LO;
    else if (int'(len_in) > PROC_MAX) len_d = HI;
    else                              len_d = T_W'(len_in);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    len_q <= LO;
    else if (load) len_q <= len_d;
  end

  // elapsed counts edges since the accepting edge, starting at 0
  assign done = (elapsed >= len_q - 1'b1);

  // R5: the captured length always lies inside the clamp range
  a_r5_len_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q >= LO) && (len_q <= HI));
endmodule

// File: rtl/srcmon_ctrl.sv
module srcmon_ctrl
  import srcmon_pkg::*;
#(
  parameter int MISS_LIMIT    = 3,
  parameter int RECOVER_COUNT = 2,
  parameter int N_W           = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           strobe,
  input  logic           t_expired,
  input  logic           busy_done,
  input  logic [N_W-1:0] run_n,
  output logic           timer_clr,
  output logic           run_clr,
  output logic           run_inc,
  output logic           win_load,
  output logic           miss_o,
  output logic           err_o,
  output logic           ok_o
);
  localparam logic [N_W-1:0] LOSS_LAST = N_W'(MISS_LIMIT - 1);
  localparam logic [N_W-1:0] GOOD_LAST = N_W'(RECOVER_COUNT - 1);

  mon_state_e state_q, state_d;
  logic miss_d, err_d, ok_d;
  logic miss_q, err_q, ok_q;

  always_comb begin
    state_d   = state_q;
    timer_clr = 1'b0;
    run_clr   = 1'b0;
    run_inc   = 1'b0;
    win_load  = 1'b0;
    miss_d    = 1'b0;
    err_d     = 1'b0;
    ok_d      = 1'b0;
    unique case (state_q)
      ST_NORMAL: begin
        if (strobe) begin
          state_d   = ST_BUSY;
          timer_clr = 1'b1;
          run_clr   = 1'b1;
          win_load  = 1'b1;
        end else if (t_expired) begin
          timer_clr = 1'b1;
          if (run_n >= LOSS_LAST) begin
            err_d   = 1'b1;
            run_clr = 1'b1;
            state_d = ST_FAULT;
          end else begin
            miss_d  = 1'b1;
            run_inc = 1'b1;
          end
        end
      end
      ST_BUSY: begin
        if (busy_done) state_d = ST_NORMAL;
      end
      ST_FAULT: begin
        if (strobe) begin
          timer_clr = 1'b1;
          if (run_n == GOOD_LAST) begin
            ok_d    = 1'b1;
            run_clr = 1'b1;
            state_d = ST_NORMAL;
          end else begin
            run_inc = 1'b1;
          end
        end else if (t_expired) begin
          timer_clr = 1'b1;
          run_clr   = 1'b1;
        end
      end
      default: state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_NORMAL;
      miss_q  <= 1'b0;
      err_q   <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      miss_q  <= miss_d;
      err_q   <= err_d;
      ok_q    <= ok_d;
    end
  end

  assign miss_o = miss_q;
  assign err_o  = err_q;
  assign ok_o   = ok_q;

  a_r9_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({miss_q, err_q, ok_q}));

  a_r2_timeout_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NORMAL && t_expired && !strobe) |=> (miss_q || err_q));

  a_r4_strobe_clears_streak: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NORMAL && strobe) |=> (run_n == '0));

  a_r5_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY) |=> !(miss_q || err_q || ok_q));

  a_r6_ok_from_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |-> ($past(state_q) == ST_FAULT) && (state_q == ST_NORMAL));

  a_r7_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULT) |=> !(miss_q || err_q));

  a_r8_strobe_beats_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NORMAL && strobe) |=> !miss_q);
endmodule

// File: rtl/src_health_monitor.sv
module src_health_monitor #(
  parameter int PERIOD        = 12,
  parameter int JITTER        = 2,
  parameter int MISS_LIMIT    = 3,
  parameter int RECOVER_COUNT = 2,
  parameter int PROC_MIN      = 2,
  parameter int PROC_MAX      = 6,
  parameter int LEN_W         = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_strobe,
  input  logic [LEN_W-1:0] proc_len,
  output logic             miss_pulse,
  output logic             err_pulse,
  output logic             ok_pulse
);
  localparam int TIMEOUT  = PERIOD + 2 * JITTER;
  localparam int T_W      = $clog2(TIMEOUT + 1);
  localparam int RUN_MAX  = (MISS_LIMIT > RECOVER_COUNT) ? MISS_LIMIT : RECOVER_COUNT;
  localparam int N_W      = $clog2(RUN_MAX + 1);

  logic           timer_clr, run_clr, run_inc, win_load;
  logic           t_expired, busy_done;
  logic [T_W-1:0] t_count;
  logic [N_W-1:0] run_n;

  initial begin
    a_r5_window_fits: assert (PROC_MIN >= 1 && PROC_MAX >= PROC_MIN && PROC_MAX < TIMEOUT);
  end

  srcmon_timer #(.LIMIT(TIMEOUT), .T_W(T_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(timer_clr),
    .count(t_count), .expired(t_expired)
  );

  srcmon_run_counter #(.LIMIT(RUN_MAX), .N_W(N_W)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(run_clr), .inc(run_inc), .count(run_n)
  );

  srcmon_busy_window #(
    .LEN_W(LEN_W), .PROC_MIN(PROC_MIN), .PROC_MAX(PROC_MAX), .T_W(T_W)
  ) u_window (
    .clk(clk), .rst_n(rst_n), .load(win_load), .len_in(proc_len),
    .elapsed(t_count), .done(busy_done)
  );

  srcmon_ctrl #(
    .MISS_LIMIT(MISS_LIMIT), .RECOVER_COUNT(RECOVER_COUNT), .N_W(N_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .strobe(data_strobe),
    .t_expired(t_expired), .busy_done(busy_done), .run_n(run_n),
    .timer_clr(timer_clr), .run_clr(run_clr), .run_inc(run_inc),
    .win_load(win_load),
    .miss_o(miss_pulse), .err_o(err_pulse), .ok_o(ok_pulse)
  );
endmodule

// File: tb/test_src_health_monitor.sv
module test_src_health_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 12, JIT = 2, KMISS = 3, NREC = 2, PMIN = 2, PMAX = 6, LW = 4;
  localparam int TMO = PER + 2 * JIT;

  logic clk = 1'b0, rst_n = 1'b0, data_strobe = 1'b0;
  logic [LW-1:0] proc_len = '0;
  logic miss_pulse, err_pulse, ok_pulse;

  int n_checks = 0, n_fail = 0;
  int mc, ec, oc, fm, fe, fo, overlap;
  logic last_miss, last_err, last_ok;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  src_health_monitor #(
    .PERIOD(PER), .JITTER(JIT), .MISS_LIMIT(KMISS), .RECOVER_COUNT(NREC),
    .PROC_MIN(PMIN), .PROC_MAX(PMAX), .LEN_W(LW)
  ) i_src_health_monitor (
    .clk(clk), .rst_n(rst_n), .data_strobe(data_strobe), .proc_len(proc_len),
    .miss_pulse(miss_pulse), .err_pulse(err_pulse), .ok_pulse(ok_pulse)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; data_strobe = 1'b0; proc_len = '0;
    repeat (3) @(negedge clk);
    chk({miss_pulse, err_pulse, ok_pulse}, 0, "R1 pulses low in reset");
    rst_n = 1'b1;
  endtask

  // advance n falling edges, counting pulses and the offset of the first of each
  task automatic watch(input int n);
    mc = 0; ec = 0; oc = 0; fm = 0; fe = 0; fo = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (int'(miss_pulse) + int'(err_pulse) + int'(ok_pulse) > 1) overlap++;
      if (miss_pulse) begin mc++; if (fm == 0) fm = k; end
      if (err_pulse)  begin ec++; if (fe == 0) fe = k; end
      if (ok_pulse)   begin oc++; if (fo == 0) fo = k; end
    end
  endtask

  // one-cycle strobe; captures the outputs produced by its sampling edge
  task automatic pulse_strobe(input int len);
    data_strobe = 1'b1;
    proc_len = LW'(len);
    @(negedge clk);
    data_strobe = 1'b0;
    last_miss = miss_pulse; last_err = err_pulse; last_ok = ok_pulse;
  endtask

  task automatic t_losses_to_fault();
    do_reset();
    watch(TMO);
    chk(mc, 1, "R1 one miss in first window");
    chk(fm, TMO, "R1 first miss offset");
    chk(ec + oc, 0, "R9 no other pulse");
    watch(TMO);
    chk(mc, 1, "R2 second miss count");
    chk(fm, TMO, "R2 second miss offset");
    watch(TMO);
    chk(mc, 0, "R3 no miss on final loss");
    chk(fe, TMO, "R3 err offset");
    chk(ec, 1, "R9 err lasts one cycle");
    watch(3 * TMO);
    chk(mc + ec, 0, "R7 fault timeouts silent");
  endtask

  task automatic t_recovery();
    pulse_strobe(3);
    chk(last_ok, 0, "R6 first recovery strobe no ok");
    watch(4);
    chk(mc + ec + oc, 0, "R6 quiet between strobes");
    pulse_strobe(3);
    chk(last_ok, 1, "R6 ok on second strobe");
    watch(2 * TMO);
    chk(mc, 2, "R6 streak zero after recovery");
    chk(ec, 0, "R6 no early err");
    watch(TMO);
    chk(ec, 1, "R3 err after recovery losses");
  endtask

  task automatic t_fault_timeout_resets();
    do_reset();
    watch(3 * TMO);
    chk(ec, 1, "R3 fault reached");
    pulse_strobe(2);
    watch(TMO);
    chk(mc + ec + oc, 0, "R7 timeout in fault silent");
    pulse_strobe(2);
    chk(last_ok, 0, "R7 progress cleared by timeout");
    watch(2);
    pulse_strobe(2);
    chk(last_ok, 1, "R6 ok after fresh run");
  endtask

  task automatic t_strobe_clears_streak();
    do_reset();
    watch(2 * TMO);
    chk(mc, 2, "R2 two misses");
    pulse_strobe(4);
    watch(2 * TMO);
    chk(mc, 2, "R4 misses restart");
    chk(ec, 0, "R4 no err after strobe");
    watch(TMO);
    chk(fe, TMO, "R4 err after full streak");
  endtask

  task automatic t_busy_probe(input int len, input int gap, input bit accepted);
    do_reset();
    pulse_strobe(len);
    if (gap > 1) watch(gap - 1);
    pulse_strobe(5);
    watch(TMO);
    chk(fm, accepted ? TMO : TMO - gap,
        $sformatf("R5 len %0d probe at edge %0d", len, gap));
  endtask

  task automatic t_same_edge();
    do_reset();
    watch(TMO - 1);
    chk(mc, 0, "R8 no miss before window end");
    pulse_strobe(2);
    chk(last_miss, 0, "R8 strobe beats timeout");
    watch(TMO);
    chk(fm, TMO, "R8 timer restarted by strobe");
  endtask

  initial begin
    overlap = 0;
    t_losses_to_fault();
    t_recovery();
    t_fault_timeout_resets();
    t_strobe_clears_streak();
    t_busy_probe(0, 2, 1'b0);
    t_busy_probe(0, 3, 1'b1);
    t_busy_probe(15, 6, 1'b0);
    t_busy_probe(15, 7, 1'b1);
    t_busy_probe(4, 4, 1'b0);
    t_busy_probe(4, 5, 1'b1);
    t_same_edge();
    chk(overlap, 0, "R9 pulses never overlap");
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule